// File: doc/BRIEF.md
# Multi-Channel Reload Down-Counter Timer

This block is a timer peripheral with two or three channels. Each channel has a 32-bit counter that counts down. One shared start register lets software run or freeze each channel. A channel's counter steps down once per prescaled tick. When it steps past zero, it reloads from that channel's constant register. At the same moment it sets a sticky underflow flag. That flag, gated by an enable bit, drives the channel's own interrupt line.

Software reaches every register over a simple bus. A write completes in a single cycle. A read is combinational. One parameter picks between two register layouts that differ only in their base offsets. The prescaler is a single free-running counter that all channels share. Each channel picks one of five division ratios from it.

For a periodic timer, software puts the period in the constant register. For a one-shot timer, it puts all ones there. Elapsed time is the bitwise inverse of the count.

Top module: `reload_timer`

## Requirements
- R1: After reset, the start register reads 0. Every constant and counter register reads 0xFFFFFFFF. Every control register reads 0. All interrupt outputs are low.
- R2: In the default layout, the start register is at byte offset 4, and channel n begins at 8+12n. In the alternate layout (ALT_MAP=1), the start register is at offset 2, and channel n begins at 4+12n. Within a channel, the constant register is at +0, the counter at +4 and the control register at +8. Any other offset reads as zero, and writes to it have no effect.
- R3: Start bit n set lets channel n count. Start bit n clear freezes its counter.
- R4: A free-running 10-bit prescale counter starts at 0 when reset is released and advances once per clock. A running channel ticks in each cycle where the low k bits of the prescale counter are all ones. Control bits [2:0] choose k: code 0 gives k=2 (/4), 1 gives 4 (/16), 2 gives 6 (/64), 3 gives 8 (/256), and codes 4 to 7 give 10 (/1024). On a tick, a nonzero counter decreases by one.
- R5: A tick with the counter at 0 loads the constant register value into the counter and sets the underflow flag (control bit 8).
- R6: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag as it was. If an underflow happens in the same cycle as the clear, the flag is set.
- R7: Interrupt output n is high exactly while channel n's underflow flag and its interrupt enable (control bit 5) are both 1.
- R8: A counter write takes effect on the next cycle, in place of any tick in that cycle. A constant write changes only later reloads.
- R9: The start register keeps one bit per channel. Bits at and above the channel count read as zero.
- R10: The control register reads back with the prescale code in [2:0], the enable in bit 5, the flag in bit 8, and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
Small constant and counter values force frequent underflows. These runs separate three cases: a correct reload of the constant, a wrap to all ones, and a missed flag. The prescale codes are mostly the fast ones, with some random codes mixed in, including the aliased codes 5 to 7. These runs show whether each ratio gates ticks on the right prescale phase. Counter writes, start toggles and flag-clearing control writes are mixed at random with running ticks. They expose errors in write-versus-tick priority, in freezing, and in set-versus-clear priority. Reads at unused offsets, and a second instance in the alternate layout, separate the two address maps.

// File: rtl/rt_pkg.sv
// Package: shared constants and helpers for the reload timer.
// Assumes the control register layout is fixed: prescale [2:0], enable bit 5, flag bit 8.
package rt_pkg;
    localparam int RT_STAGES  = 5;   // number of distinct division ratios
    localparam int RT_IE_BIT  = 5;
    localparam int RT_UF_BIT  = 8;
    localparam int RT_CTL_W   = 16;

    // Map a 3-bit prescale code to a ratio index; codes above 4 alias to the slowest.
    function automatic logic [2:0] rt_psc_index(input logic [2:0] code);
        return (code > 3'd4) ? 3'd4 : code;
    endfunction
endpackage

// File: rtl/rt_prescaler.sv
// Module: free-running prescale counter shared by all channels.
// Emits one tick strobe per ratio; ratio k ticks when the low 2(k+1) bits are all ones.
// Assumes it runs from reset release and never stops.
module rt_prescaler #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] tick
);
    localparam int PW = 2 * STAGES;

    logic [PW-1:0] pc_q;

    // Advance the shared prescale counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 1'b1;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_tick
        assign tick[k] = &pc_q[2*k+1:0];
    end
endmodule

// File: rtl/rt_channel.sv
// Module: one down-counting channel with reload, sticky underflow flag and interrupt.
// Assumes single-cycle write strobes from the top decode; a counter write beats a tick,
// and an underflow set beats a flag clear in the same cycle.
module rt_channel
    import rt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [RT_STAGES-1:0] tick_vec,
    input  logic                 wr_cst,
    input  logic                 wr_cnt,
    input  logic                 wr_ctl,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        cnt,
    output logic [DW-1:0]        cst,
    output logic [RT_CTL_W-1:0]  ctl_rd,
    output logic                 ie,
    output logic                 flag,
    output logic                 step,
    output logic                 irq
);
    logic [2:0] psc_q;

    // Pick this channel's tick from the shared prescaler.
    always_comb step = run && tick_vec[rt_psc_index(psc_q)];

    // Constant register: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      cst <= '1;
        else if (wr_cst) cst <= wdata;
    end

    // Counter: a software write first, else a decrement or a reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '1;
        else if (wr_cnt)      cnt <= wdata;
        else if (step)        cnt <= (cnt == '0) ? cst : cnt - 1'b1;
    end

    // Control fields: prescale code and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
            ie    <= 1'b0;
        end else if (wr_ctl) begin
            psc_q <= wdata[2:0];
            ie    <= wdata[RT_IE_BIT];
        end
    end

    // Sticky underflow flag: set on underflow, cleared by writing 0 to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                               flag <= 1'b0;
        else if (step && !wr_cnt && cnt == '0)    flag <= 1'b1;
        else if (wr_ctl && !wdata[RT_UF_BIT])     flag <= 1'b0;
    end

    // Assemble the control readback image.
    always_comb begin
        ctl_rd             = '0;
        ctl_rd[2:0]        = psc_q;
        ctl_rd[RT_IE_BIT]  = ie;
        ctl_rd[RT_UF_BIT]  = flag;
    end

    assign irq = flag & ie;
endmodule

// File: rtl/reload_timer.sv
// Module: top of the multi-channel reload timer: register decode, shared start
// register, shared prescaler and one channel instance per timer.
// Assumes whole-register accesses at exact byte offsets; reads are combinational.
module reload_timer
    import rt_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ALT_MAP = 0,
    parameter int ADDR_W  = 8,
    parameter int DW      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int START_OFS = (ALT_MAP != 0) ? 2 : 4;
    localparam int CH_BASE   = (ALT_MAP != 0) ? 4 : 8;
    localparam int CH_STRIDE = 12;
    localparam int CST_OFS   = 0;
    localparam int CNT_OFS   = 4;
    localparam int CTL_OFS   = 8;

    logic                              wr_hit;
    logic [NUM_CH-1:0]                 run_q;
    logic [RT_STAGES-1:0]              tick_vec;
    logic [NUM_CH-1:0][DW-1:0]         cnt_v;
    logic [NUM_CH-1:0][DW-1:0]         cst_v;
    logic [NUM_CH-1:0][RT_CTL_W-1:0]   ctl_v;
    logic [NUM_CH-1:0]                 flag_v, ie_v, ch_tick;
    logic [NUM_CH-1:0]                 wr_cst, wr_cnt, wr_ctl;

    assign wr_hit = bus_sel && bus_wr;

    // Shared start register: one run bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (wr_hit && bus_addr == ADDR_W'(START_OFS))
            run_q <= bus_wdata[NUM_CH-1:0];
    end

    rt_prescaler #(.STAGES(RT_STAGES)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_vec)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * n;

        assign wr_cst[n] = wr_hit && bus_addr == ADDR_W'(BASE + CST_OFS);
        assign wr_cnt[n] = wr_hit && bus_addr == ADDR_W'(BASE + CNT_OFS);
        assign wr_ctl[n] = wr_hit && bus_addr == ADDR_W'(BASE + CTL_OFS);

        rt_channel #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[n]),
            .tick_vec (tick_vec),
            .wr_cst   (wr_cst[n]),
            .wr_cnt   (wr_cnt[n]),
            .wr_ctl   (wr_ctl[n]),
            .wdata    (bus_wdata),
            .cnt      (cnt_v[n]),
            .cst      (cst_v[n]),
            .ctl_rd   (ctl_v[n]),
            .ie       (ie_v[n]),
            .flag     (flag_v[n]),
            .step     (ch_tick[n]),
            .irq      (irq[n])
        );
    end

    // Read multiplexer: unmatched offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(START_OFS))
            bus_rdata[NUM_CH-1:0] = run_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + CST_OFS)) bus_rdata = cst_v[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + CNT_OFS)) bus_rdata = cnt_v[n];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + CTL_OFS)) bus_rdata = DW'(ctl_v[n]);
        end
    end
endmodule

// File: rtl/rt_checker.sv
// Module: temporal checks on the reload timer, attached to every instance by bind.
// Assumes it sees the channel state and write strobes of the top module.
module rt_checker
    import rt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         run,
    input logic [NUM_CH-1:0]         ch_tick,
    input logic [NUM_CH-1:0][DW-1:0] cnt,
    input logic [NUM_CH-1:0][DW-1:0] cst,
    input logic [NUM_CH-1:0]         flag,
    input logic [NUM_CH-1:0]         ie,
    input logic [NUM_CH-1:0]         irq,
    input logic [NUM_CH-1:0]         wr_cnt,
    input logic [NUM_CH-1:0]         wr_ctl,
    input logic [DW-1:0]             wdata
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R3: a stopped channel holds its count unless software writes it.
        assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[n] && !wr_cnt[n]) |=> $stable(cnt[n]));

        // R4: a tick on a nonzero count steps it down by exactly one.
        assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[n] && !wr_cnt[n] && cnt[n] != '0) |=> (cnt[n] == $past(cnt[n]) - 1'b1));

        // R4: without a tick or a write, a running count does not move.
        assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_tick[n] && !wr_cnt[n]) |=> $stable(cnt[n]));

        // R5: underflow reloads the constant and raises the flag.
        assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[n] && !wr_cnt[n] && cnt[n] == '0) |=> (flag[n] && cnt[n] == $past(cst[n])));

        // R6: the flag only falls after a control write with bit 8 clear.
        assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[n]) |-> $past(wr_ctl[n] && !wdata[RT_UF_BIT]));

        // R7: the interrupt rises only when the flag or the enable rises.
        assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[n]) |-> ($rose(flag[n]) || $rose(ie[n])));

        // R7: the interrupt falls only when the flag or the enable falls.
        assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[n]) |-> ($fell(flag[n]) || $fell(ie[n])));

        // R8: a counter write lands on the next cycle.
        assert_count_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_cnt[n] |=> (cnt[n] == $past(wdata)));
    end
endmodule

bind reload_timer rt_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_rt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .ch_tick (ch_tick),
    .cnt     (cnt_v),
    .cst     (cst_v),
    .flag    (flag_v),
    .ie      (ie_v),
    .irq     (irq),
    .wr_cnt  (wr_cnt),
    .wr_ctl  (wr_ctl),
    .wdata   (bus_wdata)
);

// File: tb/test_reload_timer.sv
// Bench: directed corner cases plus seeded random traffic against a reference model.
module test_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, a_sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, a_rdata;
    logic [2:0]  irq;
    logic [1:0]  a_irq;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    reload_timer #(.NUM_CH(3), .ALT_MAP(0)) i_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

    reload_timer #(.NUM_CH(2), .ALT_MAP(1)) i_reload_timer_alt (
        .clk(clk), .rst_n(rst_n), .bus_sel(a_sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(a_rdata), .irq(a_irq));

    // Reference model of the main instance, built from the requirements.
    logic [31:0] m_cnt [3];
    logic [31:0] m_cst [3];
    logic [2:0]  m_psc [3];
    logic        m_ie  [3];
    logic        m_fl  [3];
    logic [2:0]  m_run;
    logic [9:0]  m_pc;

    function automatic logic [9:0] psc_mask(input logic [2:0] code);
        case (code)
            3'd0: return 10'h003;
            3'd1: return 10'h00F;
            3'd2: return 10'h03F;
            3'd3: return 10'h0FF;
            default: return 10'h3FF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc <= '0; m_run <= '0;
            for (int n = 0; n < 3; n++) begin
                m_cnt[n] <= '1; m_cst[n] <= '1; m_psc[n] <= '0; m_ie[n] <= 1'b0; m_fl[n] <= 1'b0;
            end
        end else begin
            m_pc <= m_pc + 1'b1;
            if (sel && wr && addr == 8'd4) m_run <= wdata[2:0];
            for (int n = 0; n < 3; n++) begin
                automatic int  b  = 8 + 12 * n;
                automatic logic tk = m_run[n] && ((m_pc & psc_mask(m_psc[n])) == psc_mask(m_psc[n]));
                if (sel && wr && addr == 8'(b)) m_cst[n] <= wdata;
                if (sel && wr && addr == 8'(b + 8)) begin
                    m_psc[n] <= wdata[2:0];
                    m_ie[n]  <= wdata[5];
                    if (!wdata[8]) m_fl[n] <= 1'b0;
                end
                if (sel && wr && addr == 8'(b + 4)) m_cnt[n] <= wdata;
                else if (tk) begin
                    if (m_cnt[n] == 0) begin
                        m_cnt[n] <= m_cst[n];
                        m_fl[n]  <= 1'b1;
                    end else m_cnt[n] <= m_cnt[n] - 1;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'd4) return {29'b0, m_run};
        for (int n = 0; n < 3; n++) begin
            if (a == 8'(8 + 12 * n)) return m_cst[n];
            if (a == 8'(12 + 12 * n)) return m_cnt[n];
            if (a == 8'(16 + 12 * n))
                return {23'b0, m_fl[n], 2'b0, m_ie[n], 2'b0, m_psc[n]};
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'd4) return "R3/R9";
        for (int n = 0; n < 3; n++) begin
            if (a == 8'(8 + 12 * n)) return "R8 const";
            if (a == 8'(12 + 12 * n)) return "R4/R5/R8 count";
            if (a == 8'(16 + 12 * n)) return "R5/R6/R10 control";
        end
        return "R2 undefined offset";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input bit alt = 1'b0);
        @(negedge clk);
        sel = !alt; a_sel = alt; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; a_sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(tag_of(a), rdata, m_read(a));
        sel = 1'b0;
    endtask

    task automatic rd_alt(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        a_sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(req, a_rdata, exp);
        a_sel = 1'b0;
    endtask

    // R7: interrupt lines follow flag AND enable on every cycle.
    always @(negedge clk) begin
        if (rst_n && !done)
            chk("R7 irq", {29'b0, irq}, {29'b0, m_fl[2] & m_ie[2], m_fl[1] & m_ie[1], m_fl[0] & m_ie[0]});
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image of every register.
        for (int a = 0; a < 48; a++) begin
            @(negedge clk); sel = 1'b1; wr = 1'b0; addr = 8'(a); #1;
            chk("R1 reset read", rdata, m_read(8'(a)));
        end
        sel = 1'b0;
        chk("R1 irq low", {29'b0, irq}, 32'h0);
        chk("R1 start zero", m_read(8'd4), 32'h0);

        // R9: unused start bits read zero.
        wr_reg(8'd4, 32'hFF);
        @(negedge clk); sel = 1'b1; addr = 8'd4; #1;
        chk("R9 start width", rdata, 32'h7);
        wr_reg(8'd4, 32'h0);

        // R2: undefined offsets ignore writes and read zero.
        wr_reg(8'd5, 32'hDEADBEEF);
        rd_chk(8'd5);
        rd_chk(8'd0);

        // R5/R7: directed underflow with interrupt enabled.
        wr_reg(8'd8, 32'd7);
        wr_reg(8'd12, 32'd1);
        wr_reg(8'd16, 32'h120);
        wr_reg(8'd4, 32'h1);
        repeat (12) @(negedge clk);
        rd_chk(8'd16);
        rd_chk(8'd12);
        #1 chk("R7 irq high", {31'b0, irq[0]}, 32'h1);
        // R6: writing 1 to the flag keeps it; writing 0 clears it.
        wr_reg(8'd4, 32'h0);
        wr_reg(8'd16, 32'h120);
        rd_chk(8'd16);
        wr_reg(8'd16, 32'h020);
        rd_chk(8'd16);
        #1 chk("R6 flag cleared irq", {31'b0, irq[0]}, 32'h0);

        // R3: a frozen channel keeps its count.
        wr_reg(8'd24, 32'd100);
        repeat (40) @(negedge clk);
        rd_chk(8'd24);

        // R2: alternate layout.
        rd_alt(8'd2, 32'h0, "R2 alt start reset");
        rd_alt(8'd4, 32'hFFFFFFFF, "R2 alt ch0 const at 4");
        wr_reg(8'd16, 32'h1234, 1'b1);
        rd_alt(8'd16, 32'h1234, "R2 alt ch1 const at 16");
        wr_reg(8'd2, 32'h3, 1'b1);
        rd_alt(8'd2, 32'h3, "R2 alt start at 2");
        rd_alt(8'd12, 32'h0, "R2 alt ch0 control at 12");

        // Random traffic with small values to force frequent underflows.
        for (int i = 0; i < 5000; i++) begin
            automatic int op = $urandom % 10;
            automatic int ch = $urandom % 3;
            automatic logic [7:0] b = 8'(8 + 12 * ch);
            case (op)
                0: wr_reg(8'd4, $urandom % 8);
                1: begin
                    automatic logic [2:0] p = ($urandom % 5 == 0) ? 3'($urandom) : 3'($urandom % 2);
                    wr_reg(b + 8'd8, ($urandom & 32'h0000_0120) | 32'(p));
                end
                2: wr_reg(b + 8'd4, $urandom % 40);
                3: wr_reg(b, $urandom % 50);
                4: @(negedge clk);
                default: rd_chk(8'($urandom % 48));
            endcase
        end
        for (int a = 4; a < 48; a++) rd_chk(8'(a));
        finish_run();
    end
endmodule